// File: doc/BRIEF.md
# Redundant Operand Forwarder

This block sits between the commit stage of the leading (main) thread and the decode stage of the trailing redundant thread in a dual-thread redundant-execution core. Each main-thread result that commits with a successful validation, loaded values included, is pushed into a small commit-ordered queue. Loads that validate this way place their value in this queue only, never in a separate load value store. The redundant thread decodes in the same program order. When it decodes an instruction that will not be re-executed, the block moves the head of the queue into a per-register operand buffer entry and marks that entry valid. When it decodes an instruction that will be re-executed, the block clears the valid mark of the destination entry, because the re-executed result will supersede the forwarded one.

Redundant instructions that do execute look up their source registers in the operand buffer through a set of combinational lookup ports. A hit supplies the validated value. The block also decides whether a redundant store may be dropped from re-execution. A store is dropped only when its address was validated, which means its re-execute flag is low, and when the buffer entry of its data register is valid.

A flush input, and likewise reset, empties the queue and invalidates every buffer entry. When the queue is full, a ready signal tells the commit stage to hold its push. A fill request that finds the queue empty is refused and raises an error pulse. A value pushed in a cycle is never visible to a pop in that same cycle.

Top module: `rof_top`

## Requirements
- R1: After reset every buffer entry is invalid, `cm_ready` is 1 and the queue holds no value.
- R2: A push happens when `cm_valid` and `cm_ready` are both 1 in a cycle; it appends `cm_data` at the tail, and values leave in the order they were pushed.
- R3: A decode with `dc_valid`=1 and `dc_exec`=0 (non-executing) on a non-empty queue removes the head value, writes it into entry `dc_dst` and sets that entry valid from the next cycle.
- R4: A decode with `dc_valid`=1 and `dc_exec`=1 (executing) clears the valid bit of entry `dc_dst` from the next cycle and leaves the queue untouched.
- R5: Lookup port p reads register `src_idx[p*REG_W +: REG_W]` combinationally: `src_hit[p]` is that entry's valid bit and `src_val[p*DATA_W +: DATA_W]` is its value on a hit, 0 on a miss.
- R6: `st_skip` is 1 exactly when `st_valid`=1, `st_reexec`=0 and the entry of `st_reg` is valid.
- R7: A non-executing decode while the queue is empty drives `dc_underflow` to 1 in that cycle and changes no buffer entry.
- R8: `cm_ready` is 0 while the queue holds DEPTH values; a push offered then is dropped, even if a pop happens in the same cycle.
- R9: A push and a non-executing decode in the same cycle on an empty queue: the decode is refused with `dc_underflow`=1, and the pushed value stays at the head for a later decode.
- R10: A push and a pop in the same cycle on a queue that is neither empty nor full both take effect, and the queue's order is kept.
- R11: While `flush`=1, `cm_ready` and `dc_underflow` are 0; on the following cycle the queue is empty and all entries are invalid; pushes and decodes of the flush cycle are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Discard queue content and invalidate all entries |
| cm_valid | input | 1 | Validated main-thread result offered at commit |
| cm_data | input | DATA_W | Result value (register or loaded value) |
| cm_ready | output | 1 | Queue can accept a push this cycle |
| dc_valid | input | 1 | Redundant-thread decode present |
| dc_exec | input | 1 | 1: instruction re-executes, 0: skips execution |
| dc_dst | input | REG_W | Destination architectural register |
| dc_underflow | output | 1 | Non-executing decode found the queue empty |
| src_idx | input | NSRC*REG_W | Source register per lookup port |
| src_hit | output | NSRC | Entry valid per lookup port |
| src_val | output | NSRC*DATA_W | Forwarded value per lookup port, 0 on miss |
| st_valid | input | 1 | Redundant store under evaluation |
| st_reexec | input | 1 | Store address still needs re-execution |
| st_reg | input | REG_W | Store-data register |
| st_skip | output | 1 | Store may be dropped from re-execution |

## Verification
The bench drives directed patterns first. It fills the queue to capacity and drains it into several registers, which separates correct FIFO order from swapped or stale values. It mixes executing and non-executing decodes on one register so that invalidation can be told apart from overwrite. It pairs pushes with pops on an empty, partly filled and full queue, which separates the no-bypass, concurrent and backpressure rules. The store decision is swept over every register and both values of the re-execute flag. A pseudo-random mix of pushes, decodes and rare flushes then runs against an arithmetic model. After every cycle all registers are read through the lookup ports, so a wrong index, lost value or stuck valid bit shows up in the next sweep.

// File: rtl/rof_pkg.sv
package rof_pkg;

  // Kind of redundant-thread decode seen by the buffer.
  typedef enum logic [1:0] {
    DEC_NONE = 2'd0,
    DEC_FILL = 2'd1,   // non-executing: take value from queue
    DEC_KILL = 2'd2    // executing: drop forwarded value
  } dec_kind_e;

  // Circular pointer advance for a queue of arbitrary depth.
  function automatic int unsigned wrap_inc(input int unsigned ptr,
                                           input int unsigned depth);
    return (ptr + 1 >= depth) ? 0 : ptr + 1;
  endfunction

  // Occupancy after one cycle with optional push and pop.
  function automatic int unsigned occ_next(input int unsigned occ,
                                           input logic push,
                                           input logic pop);
    return occ + (push ? 1 : 0) - (pop ? 1 : 0);
  endfunction

endpackage

// File: rtl/rof_cvq.sv
module rof_cvq #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              push_req,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop_req,
  output logic              ready,
  output logic              pop_ok,
  output logic              underflow,
  output logic [DATA_W-1:0] head_data
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wptr, rptr;
  logic [CNT_W-1:0]  count;

  // Named internal events
  logic empty, full, push_fire;

  assign empty     = (count == '0);
  assign full      = (count == FULL_CNT);
  assign ready     = !full && !flush;
  assign push_fire = push_req && ready;
  // Occupancy is registered, so a same-cycle push never feeds a pop.
  assign pop_ok    = pop_req && !empty && !flush;
  assign underflow = pop_req && empty && !flush;
  assign head_data = mem[rptr];

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push_fire)
        wptr <= PTR_W'(rof_pkg::wrap_inc(int'(wptr), DEPTH));
      if (pop_ok)
        rptr <= PTR_W'(rof_pkg::wrap_inc(int'(rptr), DEPTH));
      count <= CNT_W'(rof_pkg::occ_next(int'(count), push_fire, pop_ok));
    end
  end

  always_ff @(posedge clk) begin
    if (push_fire)
      mem[wptr] <= push_data;
  end

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL_CNT);

  p_full_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop_ok && !flush) |=> full);

  p_flush_empties_r11: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (count == '0));

  p_no_bypass_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && push_req && pop_req && !flush) |=> (count == CNT_W'(1)));

endmodule

// File: rtl/rof_opbuf.sv
module rof_opbuf #(
  parameter int DATA_W = 16,
  parameter int NREG   = 8,
  parameter int NSRC   = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   flush,
  input  logic                   fill_en,
  input  logic [$clog2(NREG)-1:0] fill_idx,
  input  logic [DATA_W-1:0]      fill_data,
  input  logic                   kill_en,
  input  logic [$clog2(NREG)-1:0] kill_idx,
  input  logic [NSRC*$clog2(NREG)-1:0] src_idx,
  output logic [NSRC-1:0]        src_hit,
  output logic [NSRC*DATA_W-1:0] src_val,
  input  logic [$clog2(NREG)-1:0] st_idx,
  output logic                   st_ok
);
  localparam int REG_W = $clog2(NREG);

  logic [NREG-1:0]   vld;
  logic [DATA_W-1:0] val [NREG];

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      vld <= '0;
    end else begin
      if (kill_en) vld[kill_idx] <= 1'b0;
      if (fill_en) vld[fill_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en)
      val[fill_idx] <= fill_data;
  end

  for (genvar g = 0; g < NSRC; g++) begin : g_lookup
    logic [REG_W-1:0] idx;
    assign idx = src_idx[g*REG_W +: REG_W];
    assign src_hit[g] = vld[idx];
    assign src_val[g*DATA_W +: DATA_W] = vld[idx] ? val[idx] : '0;
  end

  assign st_ok = vld[st_idx];

  p_fill_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && !flush) |=> (vld[$past(fill_idx)] &&
                             val[$past(fill_idx)] == $past(fill_data)));

  p_kill_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (kill_en && !fill_en && !flush) |=> !vld[$past(kill_idx)]);

  p_flush_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (vld == '0));

endmodule

// File: rtl/rof_decide.sv
module rof_decide #(
  parameter int NREG = 8
) (
  input  logic                    flush,
  input  logic                    dc_valid,
  input  logic                    dc_exec,
  input  logic [$clog2(NREG)-1:0] dc_dst,
  input  logic                    pop_ok,
  output logic                    pop_req,
  output logic                    fill_en,
  output logic                    kill_en,
  output logic [$clog2(NREG)-1:0] upd_idx,
  input  logic                    st_valid,
  input  logic                    st_reexec,
  input  logic                    st_data_ok,
  output logic                    st_skip
);
  rof_pkg::dec_kind_e kind;

  always_comb begin
    if (!dc_valid || flush) kind = rof_pkg::DEC_NONE;
    else if (dc_exec)       kind = rof_pkg::DEC_KILL;
    else                    kind = rof_pkg::DEC_FILL;
  end

  assign pop_req = (kind == rof_pkg::DEC_FILL);
  assign fill_en = pop_req && pop_ok;
  assign kill_en = (kind == rof_pkg::DEC_KILL);
  assign upd_idx = dc_dst;

  // Both the address and the data of the store must be validated.
  assign st_skip = st_valid && !st_reexec && st_data_ok;

  always_comb begin
    a_skip_needs_addr_r6: assert (!st_skip || !st_reexec);
    a_one_update_r3: assert (!(fill_en && kill_en));
  end

endmodule

// File: rtl/rof_top.sv
module rof_top #(
  parameter int DATA_W = 16,
  parameter int NREG   = 8,
  parameter int DEPTH  = 4,
  parameter int NSRC   = 2,
  localparam int REG_W = $clog2(NREG)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   flush,
  input  logic                   cm_valid,
  input  logic [DATA_W-1:0]      cm_data,
  output logic                   cm_ready,
  input  logic                   dc_valid,
  input  logic                   dc_exec,
  input  logic [REG_W-1:0]       dc_dst,
  output logic                   dc_underflow,
  input  logic [NSRC*REG_W-1:0]  src_idx,
  output logic [NSRC-1:0]        src_hit,
  output logic [NSRC*DATA_W-1:0] src_val,
  input  logic                   st_valid,
  input  logic                   st_reexec,
  input  logic [REG_W-1:0]       st_reg,
  output logic                   st_skip
);
  logic              pop_req, pop_ok, fill_en, kill_en, st_data_ok;
  logic [REG_W-1:0]  upd_idx;
  logic [DATA_W-1:0] head_data;

  rof_cvq #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_cvq (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .push_req  (cm_valid),
    .push_data (cm_data),
    .pop_req   (pop_req),
    .ready     (cm_ready),
    .pop_ok    (pop_ok),
    .underflow (dc_underflow),
    .head_data (head_data)
  );

  rof_decide #(.NREG(NREG)) u_decide (
    .flush      (flush),
    .dc_valid   (dc_valid),
    .dc_exec    (dc_exec),
    .dc_dst     (dc_dst),
    .pop_ok     (pop_ok),
    .pop_req    (pop_req),
    .fill_en    (fill_en),
    .kill_en    (kill_en),
    .upd_idx    (upd_idx),
    .st_valid   (st_valid),
    .st_reexec  (st_reexec),
    .st_data_ok (st_data_ok),
    .st_skip    (st_skip)
  );

  rof_opbuf #(.DATA_W(DATA_W), .NREG(NREG), .NSRC(NSRC)) u_opbuf (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .fill_en   (fill_en),
    .fill_idx  (upd_idx),
    .fill_data (head_data),
    .kill_en   (kill_en),
    .kill_idx  (upd_idx),
    .src_idx   (src_idx),
    .src_hit   (src_hit),
    .src_val   (src_val),
    .st_idx    (st_reg),
    .st_ok     (st_data_ok)
  );

  p_underflow_no_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dc_underflow |-> !fill_en);

  p_flush_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (!cm_ready && !dc_underflow));

endmodule

// File: tb/tb_rof_top.sv
module tb_rof_top;
  localparam int DATA_W = 16;
  localparam int NREG   = 8;
  localparam int DEPTH  = 4;
  localparam int NSRC   = 2;
  localparam int REG_W  = 3;

  logic clk = 1'b0;
  logic rst_n, flush, cm_valid, cm_ready, dc_valid, dc_exec, dc_underflow;
  logic st_valid, st_reexec, st_skip;
  logic [DATA_W-1:0] cm_data;
  logic [REG_W-1:0]  dc_dst, st_reg;
  logic [NSRC*REG_W-1:0]  src_idx;
  logic [NSRC-1:0]        src_hit;
  logic [NSRC*DATA_W-1:0] src_val;

  always #5 clk = ~clk;

  rof_top #(.DATA_W(DATA_W), .NREG(NREG), .DEPTH(DEPTH), .NSRC(NSRC)) dut (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .cm_valid(cm_valid), .cm_data(cm_data), .cm_ready(cm_ready),
    .dc_valid(dc_valid), .dc_exec(dc_exec), .dc_dst(dc_dst),
    .dc_underflow(dc_underflow),
    .src_idx(src_idx), .src_hit(src_hit), .src_val(src_val),
    .st_valid(st_valid), .st_reexec(st_reexec), .st_reg(st_reg),
    .st_skip(st_skip)
  );

  int nchk = 0;
  int nfail = 0;

  // Reference model state
  logic [DATA_W-1:0] mq[$];
  bit                mv [NREG];
  logic [DATA_W-1:0] md [NREG];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic idle();
    flush = 0; cm_valid = 0; cm_data = '0; dc_valid = 0; dc_exec = 0;
    dc_dst = '0; st_valid = 0; st_reexec = 0; st_reg = '0; src_idx = '0;
  endtask

  // R5: read every register through both lookup ports (at negedge).
  task automatic sweep(input string req);
    for (int k = 0; k < NREG / 2; k++) begin
      int a = k;
      int b = k + NREG / 2;
      src_idx = {REG_W'(b), REG_W'(a)};
      #1;
      check(src_hit[0] == mv[a], req, "R5 hit port0", int'(src_hit[0]), int'(mv[a]));
      check(src_val[DATA_W-1:0] == (mv[a] ? md[a] : '0), req, "R5 value port0",
            int'(src_val[DATA_W-1:0]), mv[a] ? int'(md[a]) : 0);
      check(src_hit[1] == mv[b], req, "R5 hit port1", int'(src_hit[1]), int'(mv[b]));
      check(src_val[2*DATA_W-1:DATA_W] == (mv[b] ? md[b] : '0), req, "R5 value port1",
            int'(src_val[2*DATA_W-1:DATA_W]), mv[b] ? int'(md[b]) : 0);
    end
  endtask

  // One cycle of stimulus, started at a negedge; ends at the next negedge
  // after sweeping the buffer, then waits one more negedge.
  task automatic step(input bit cv, input logic [DATA_W-1:0] cd, input bit dv,
                      input bit de, input logic [REG_W-1:0] dd, input bit fl,
                      input string req);
    bit exp_ready, exp_uf;
    flush = fl; cm_valid = cv; cm_data = cd;
    dc_valid = dv; dc_exec = de; dc_dst = dd;
    #1;
    exp_ready = (mq.size() < DEPTH) && !fl;
    exp_uf    = dv && !de && (mq.size() == 0) && !fl;
    check(cm_ready == exp_ready, req, "cm_ready", int'(cm_ready), int'(exp_ready));
    check(dc_underflow == exp_uf, req, "dc_underflow", int'(dc_underflow), int'(exp_uf));
    // model update from pre-cycle state
    if (fl) begin
      mq.delete();
      foreach (mv[i]) mv[i] = 0;
    end else begin
      bit do_pop = dv && !de && (mq.size() > 0);
      bit do_push = cv && exp_ready;
      if (do_pop) begin
        md[dd] = mq.pop_front();
        mv[dd] = 1;
      end
      if (dv && de) mv[dd] = 0;
      if (do_push) mq.push_back(cd);
    end
    @(posedge clk);
    @(negedge clk);
    idle();
    sweep(req);
    @(negedge clk);
  endtask

  // R6: store drop decision over every register and both flag values.
  task automatic store_sweep();
    for (int r = 0; r < NREG; r++) begin
      for (int re = 0; re < 2; re++) begin
        bit exp;
        st_valid = 1; st_reexec = re[0]; st_reg = REG_W'(r);
        #1;
        exp = !re[0] && mv[r];
        check(st_skip == exp, "R6", "st_skip", int'(st_skip), int'(exp));
        @(negedge clk);
      end
    end
    st_valid = 0; st_reg = REG_W'(1);
    #1;
    check(st_skip == 0, "R6", "st_skip without st_valid", int'(st_skip), 0);
    idle();
    @(negedge clk);
  endtask

  initial begin
    #200000;
    nfail++;
    $display("FAIL watchdog: got 0 expected 1 (run did not finish)");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    logic [15:0] lf;
    idle();
    foreach (mv[i]) begin mv[i] = 0; md[i] = '0; end
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1: reset state
    #1;
    check(cm_ready == 1, "R1", "cm_ready after reset", int'(cm_ready), 1);
    check(src_hit == '0, "R1", "no valid entry after reset", int'(src_hit), 0);
    sweep("R1");
    @(negedge clk);
    step(0, 16'h0, 1, 0, 3'd2, 0, "R1 R7");       // empty queue: underflow

    // R2 / R8: fill to capacity, then a refused push
    for (int i = 0; i < DEPTH; i++)
      step(1, DATA_W'(16'h1100 + 17 * i), 0, 0, 3'd0, 0, "R2");
    step(1, 16'hDEAD, 0, 0, 3'd0, 0, "R8");
    // R8: full queue, push plus pop in one cycle: push is still dropped
    step(1, 16'hBEEF, 1, 0, 3'd7, 0, "R8");
    // R3 / R2: drain in order into distinct registers
    for (int i = 0; i < DEPTH - 1; i++)
      step(0, 16'h0, 1, 0, REG_W'(i), 0, "R3");
    // R4: executing decode invalidates, queue unchanged
    step(0, 16'h0, 1, 1, 3'd1, 0, "R4");
    step(0, 16'h0, 1, 1, 3'd5, 0, "R4");           // already invalid entry
    // R7: pop on empty leaves entries alone
    step(0, 16'h0, 1, 0, 3'd0, 0, "R7");
    // R9: push and pop together on empty queue
    step(1, 16'h4242, 1, 0, 3'd4, 0, "R9");
    step(0, 16'h0, 1, 0, 3'd4, 0, "R9");
    // R10: concurrent push and pop on partly filled queue
    step(1, 16'h0A0A, 0, 0, 3'd0, 0, "R10");
    step(1, 16'h0B0B, 0, 0, 3'd0, 0, "R10");
    step(1, 16'h0C0C, 1, 0, 3'd6, 0, "R10");
    step(1, 16'h0D0D, 1, 0, 3'd2, 0, "R10");
    step(0, 16'h0, 1, 0, 3'd3, 0, "R10");
    // R6: store decisions with mixed valid entries
    store_sweep();
    // R11: flush with pending push and decode
    step(1, 16'h7777, 1, 0, 3'd5, 1, "R11");
    step(0, 16'h0, 1, 0, 3'd5, 0, "R11");
    store_sweep();

    // Every register: fill, overwrite, invalidate (R3, R4)
    for (int r = 0; r < NREG; r++) begin
      step(1, DATA_W'(16'h2000 + 257 * r), 0, 0, 3'd0, 0, "R2");
      step(1, DATA_W'(16'h3000 + 31 * r), 1, 0, REG_W'(r), 0, "R3");
      step(0, 16'h0, 1, 0, REG_W'(r), 0, "R3");
      if (r % 2 == 1) step(0, 16'h0, 1, 1, REG_W'(r), 0, "R4");
    end
    store_sweep();

    // Pseudo-random mix against the model (R2, R3, R4, R7, R8, R10, R11)
    lf = 16'hACE1;
    for (int n = 0; n < 300; n++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      step(lf[0], lf ^ 16'h5A5A, lf[1] | lf[2], lf[3] & lf[4], lf[7:5],
           lf[15:11] == 5'd0, "R10 mix");
    end
    store_sweep();

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

endmodule